// File: doc/BRIEF.md
# Executed-Opcode Pixel Serializer

This block sits beside a 65C02-class processor and turns part of the instruction stream into video. On every opcode fetch that uses one of the processor's one-byte, one-cycle undefined opcodes, the upper five bits of that opcode become picture data. A program that draws the screen simply executes a run of these harmless opcodes during the active part of a scan line. Anything else the processor fetches, and every cycle that is not an opcode fetch, produces dark pixels. This keeps the display black while ordinary code runs.

The block runs on the dot clock. A one-dot-clock strobe from the surrounding logic marks the dot on which the data bus and the opcode-fetch flag are valid for the current processor cycle. One of three variants is chosen when the block is built. The bitmap variant shifts five pixels per processor cycle, so a processor cycle spans five dots. The text variant adds a sixth, always-dark spacing pixel, so a cycle spans six dots. The grayscale variant has a processor cycle of a single dot and turns each five-bit code into an intensity, where code zero means blanking.

Top module: `opix_serializer`

## Requirements
- R1: A fetch qualifies as pixel data only when the fetch flag is high on the strobe dot and data bits [1:0] are both 1. The payload is data bits [7:3].
- R2: Opcodes 8'hCB and 8'hDB never qualify. They load an all-zero payload even with the fetch flag high.
- R3: A strobe with the fetch flag low, or with a non-qualifying byte, loads an all-zero payload. The pixels that follow are dark.
- R4: Bitmap variant: the five payload bits appear on pix_out MSB first. Bit 4 is driven on the dot right after the strobe dot, and each later bit one dot after the one before it.
- R5: Text variant: the five payload bits appear as in R4. The sixth dot after the strobe carries a pixel that is always 0.
- R6: When strobes arrive exactly one group apart (5 dots in bitmap, 6 dots in text), the first pixel of the new group follows the last pixel of the previous group with no gap.
- R7: Grayscale variant: on the dot after a strobe, level equals the payload, and blank is 1 exactly when the payload is 0.
- R8: After a synchronous reset, pix_out is 0. The bitmap and text variants then show level 1 with blank 0. The grayscale variant shows level 0 with blank 1.
- R9: Bitmap and text variants: level is 31 while pix_out is 1 and 1 while pix_out is 0. blank stays 0.
- R10: Grayscale variant: pix_out is 1 exactly when the current level is non-zero.
- R11: Grayscale variant: on dots without a strobe, level, blank and pix_out hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_data | input | 8 | Processor data bus |
| cpu_sync | input | 1 | High during an opcode fetch cycle |
| cyc_stb | input | 1 | One-dot strobe marking the dot where bus and fetch flag are sampled |
| pix_out | output | 1 | Serial monochrome pixel |
| level | output | 5 | Intensity (grayscale) or lit/dark level (shift variants) |
| blank | output | 1 | Blanking indication |

## Verification
The assertions take for granted that the strobe is regular. In the shift variants a strobe comes exactly once every group length in dots, so the dot counter in the checker stays aligned with the separator position. In the grayscale variant the strobe may be high on every dot or left low to test holding. The bench drives bus, fetch flag and strobe on the falling clock edge only, and it always spaces strobes one full group apart, including across the sweep of all 256 byte values with the fetch flag both low and high.

// File: rtl/opix_pkg.sv
package opix_pkg;

  typedef enum int {
    OPX_BITMAP = 0,
    OPX_TEXT   = 1,
    OPX_GRAY   = 2
  } opx_mode_e;

  function automatic int unsigned opx_sep_dots(input int mode);
    return (mode == OPX_TEXT) ? 1 : 0;
  endfunction

endpackage

// File: rtl/opix_decode.sv
module opix_decode #(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned PAY_W   = 5,
  parameter int unsigned PAY_LSB = 3,
  parameter logic [BUS_W-1:0] EXCL_A = 8'hCB,
  parameter logic [BUS_W-1:0] EXCL_B = 8'hDB
) (
  input  logic [BUS_W-1:0] bus,
  input  logic             fetch,
  output logic [PAY_W-1:0] payload
);

  logic tag_ok;
  logic excluded;
  logic take;

  always_comb begin
    tag_ok   = &bus[1:0];
    excluded = (bus == EXCL_A) || (bus == EXCL_B);
    take     = fetch && tag_ok && !excluded;
    payload  = take ? bus[PAY_LSB +: PAY_W] : '0;
  end

endmodule

// File: rtl/opix_shifter.sv
module opix_shifter #(
  parameter int unsigned PAY_W     = 5,
  parameter int unsigned SEP_W     = 0,
  parameter int unsigned LVL_W     = 5,
  parameter logic [LVL_W-1:0] LVL_ON  = 5'd31,
  parameter logic [LVL_W-1:0] LVL_OFF = 5'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAY_W-1:0] payload,
  output logic             pix,
  output logic [LVL_W-1:0] level,
  output logic             blank
);

  localparam int unsigned GRP_W = PAY_W + SEP_W;

  logic [GRP_W-1:0] sh_q;
  logic [GRP_W-1:0] sh_d;
  logic [GRP_W-1:0] group;

  generate
    if (SEP_W > 0) begin : g_sep
      assign group = {payload, {SEP_W{1'b0}}};
    end else begin : g_nosep
      assign group = payload;
    end
  endgenerate

  always_comb begin
    if (load) sh_d = group;
    else      sh_d = {sh_q[GRP_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      level <= LVL_OFF;
    end else begin
      sh_q  <= sh_d;
      level <= sh_d[GRP_W-1] ? LVL_ON : LVL_OFF;
    end
  end

  assign pix   = sh_q[GRP_W-1];
  assign blank = 1'b0;

endmodule

// File: rtl/opix_gray.sv
module opix_gray #(
  parameter int unsigned PAY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAY_W-1:0] payload,
  output logic             pix,
  output logic [PAY_W-1:0] level,
  output logic             blank
);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      blank <= 1'b1;
      pix   <= 1'b0;
    end else if (load) begin
      level <= payload;
      blank <= (payload == '0);
      pix   <= |payload;
    end
  end

endmodule

// File: rtl/opix_serializer.sv
module opix_serializer
  import opix_pkg::*;
#(
  parameter int          MODE    = OPX_BITMAP,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned PAY_W   = 5,
  parameter int unsigned PAY_LSB = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] cpu_data,
  input  logic             cpu_sync,
  input  logic             cyc_stb,
  output logic             pix_out,
  output logic [PAY_W-1:0] level,
  output logic             blank
);

  localparam int unsigned SEP_W = opx_sep_dots(MODE);
  localparam logic [PAY_W-1:0] LVL_ON  = '1;
  localparam logic [PAY_W-1:0] LVL_OFF = PAY_W'(1);

  logic [PAY_W-1:0] payload;

  opix_decode #(
    .BUS_W  (BUS_W),
    .PAY_W  (PAY_W),
    .PAY_LSB(PAY_LSB)
  ) u_decode (
    .bus    (cpu_data),
    .fetch  (cpu_sync),
    .payload(payload)
  );

  generate
    if (MODE == OPX_GRAY) begin : g_gray
      opix_gray #(
        .PAY_W(PAY_W)
      ) u_gray (
        .clk    (clk),
        .rst    (rst),
        .load   (cyc_stb),
        .payload(payload),
        .pix    (pix_out),
        .level  (level),
        .blank  (blank)
      );
    end else begin : g_shift
      opix_shifter #(
        .PAY_W  (PAY_W),
        .SEP_W  (SEP_W),
        .LVL_W  (PAY_W),
        .LVL_ON (LVL_ON),
        .LVL_OFF(LVL_OFF)
      ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (cyc_stb),
        .payload(payload),
        .pix    (pix_out),
        .level  (level),
        .blank  (blank)
      );
    end
  endgenerate

endmodule

// File: rtl/opix_checker.sv
module opix_checker #(
  parameter int          MODE    = 0,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned PAY_W   = 5,
  parameter int unsigned PAY_LSB = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [BUS_W-1:0] cpu_data,
  input logic             cpu_sync,
  input logic             cyc_stb,
  input logic             pix_out,
  input logic [PAY_W-1:0] level,
  input logic             blank
);

  localparam int unsigned CNT_W = $clog2(PAY_W + 3) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] dots;
  logic             qual;

  assign qual = cpu_sync && (&cpu_data[1:0]) &&
                (cpu_data != 8'hCB) && (cpu_data != 8'hDB);

  always_ff @(posedge clk) begin
    if (rst)                 dots <= CNT_MAX;
    else if (cyc_stb)        dots <= '0;
    else if (dots != CNT_MAX) dots <= dots + 1'b1;
  end

  // R3: no fetch flag means the next pixel is dark
  a_r3_nosync_dark: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !cpu_sync) |=> !pix_out);

  // R2: excluded opcodes stay dark
  a_r2_excluded_dark: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && cpu_sync && (cpu_data == 8'hCB || cpu_data == 8'hDB)) |=> !pix_out);

  generate
    if (MODE == 2) begin : g_gray_chk
      a_r7_gray_level: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && qual) |=> (level == $past(cpu_data[PAY_LSB +: PAY_W])));
      a_r7_blank_code: assert property (@(posedge clk) disable iff (rst)
        (blank == (level == '0)));
      a_r10_pix_lit: assert property (@(posedge clk) disable iff (rst)
        (pix_out == (level != '0)));
      a_r11_gray_hold: assert property (@(posedge clk) disable iff (rst)
        !cyc_stb |=> ($stable(level) && $stable(blank)));
    end else begin : g_shift_chk
      a_r9_shift_level: assert property (@(posedge clk) disable iff (rst)
        (!blank && (level == (pix_out ? 5'd31 : 5'd1))));
      if (MODE == 1) begin : g_text_chk
        a_r5_separator: assert property (@(posedge clk) disable iff (rst)
          (dots == CNT_W'(PAY_W)) |-> !pix_out);
      end
    end
  endgenerate

endmodule

bind opix_serializer opix_checker #(
  .MODE   (MODE),
  .BUS_W  (BUS_W),
  .PAY_W  (PAY_W),
  .PAY_LSB(PAY_LSB)
) u_opix_checker (
  .clk     (clk),
  .rst     (rst),
  .cpu_data(cpu_data),
  .cpu_sync(cpu_sync),
  .cyc_stb (cyc_stb),
  .pix_out (pix_out),
  .level   (level),
  .blank   (blank)
);

// File: tb/opix_serializer_bench.sv
module opix_serializer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data = 8'h00;
  logic       sync = 1'b0;
  logic       stb_b = 1'b0;
  logic       stb_t = 1'b0;
  logic       stb_g = 1'b0;

  logic       pix_b, pix_t, pix_g;
  logic [4:0] lvl_b, lvl_t, lvl_g;
  logic       blk_b, blk_t, blk_g;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opix_serializer #(.MODE(0)) u_opix_serializer (
    .clk(clk), .rst(rst), .cpu_data(data), .cpu_sync(sync), .cyc_stb(stb_b),
    .pix_out(pix_b), .level(lvl_b), .blank(blk_b));

  opix_serializer #(.MODE(1)) u_opix_serializer_text (
    .clk(clk), .rst(rst), .cpu_data(data), .cpu_sync(sync), .cyc_stb(stb_t),
    .pix_out(pix_t), .level(lvl_t), .blank(blk_t));

  opix_serializer #(.MODE(2)) u_opix_serializer_gray (
    .clk(clk), .rst(rst), .cpu_data(data), .cpu_sync(sync), .cyc_stb(stb_g),
    .pix_out(pix_g), .level(lvl_g), .blank(blk_g));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_pay(input logic [7:0] b, input logic s);
    bit q;
    q = s && (b[1:0] == 2'b11) && (b != 8'hCB) && (b != 8'hDB);
    return q ? b[7:3] : 5'd0;
  endfunction

  // called at a falling edge; strobes one group and samples each dot
  task automatic do_group(input int m, input logic [7:0] b, input logic s);
    logic [4:0] pay;
    int g;
    string tag;
    pay = exp_pay(b, s);
    g = (m == 0) ? 5 : ((m == 1) ? 6 : 1);
    if (s && (b == 8'hCB || b == 8'hDB)) tag = "R2";
    else if (pay == 5'd0) tag = "R3 R1";
    else tag = "R1";
    data = b;
    sync = s;
    stb_b = (m == 0);
    stb_t = (m == 1);
    stb_g = (m == 2);
    for (int k = 0; k < g; k++) begin
      @(negedge clk);
      if (k == 0) begin
        stb_b = 1'b0;
        stb_t = 1'b0;
        stb_g = 1'b0;
      end
      if (m == 2) begin
        chk(lvl_g == pay, {"R7 level ", tag}, lvl_g, pay);
        chk(blk_g == (pay == 5'd0), "R7 blank", blk_g, pay == 5'd0);
        chk(pix_g == (pay != 5'd0), "R10 pix", pix_g, pay != 5'd0);
      end else begin
        logic p;
        logic [4:0] l;
        logic bl;
        logic e;
        p  = (m == 0) ? pix_b : pix_t;
        l  = (m == 0) ? lvl_b : lvl_t;
        bl = (m == 0) ? blk_b : blk_t;
        e  = (k < 5) ? pay[4-k] : 1'b0;
        if (k == 5) chk(p == e, "R5 separator", p, e);
        else if (m == 0) chk(p == e, {"R4 R6 ", tag}, p, e);
        else chk(p == e, {"R5 R6 ", tag}, p, e);
        chk(l == (e ? 5'd31 : 5'd1), "R9 level", l, e ? 31 : 1);
        chk(bl == 1'b0, "R9 blank", bl, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(pix_b == 0 && pix_t == 0 && pix_g == 0, "R8 pix", pix_b | pix_t | pix_g, 0);
    chk(lvl_b == 1 && lvl_t == 1, "R8 shift level", lvl_b, 1);
    chk(blk_b == 0 && blk_t == 0, "R8 shift blank", blk_b | blk_t, 0);
    chk(lvl_g == 0, "R8 gray level", lvl_g, 0);
    chk(blk_g == 1, "R8 gray blank", blk_g, 1);
    rst = 1'b0;
    @(negedge clk);

    // bitmap sweep, back to back groups
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 256; b++)
        do_group(0, 8'(b), s[0]);
    // text sweep
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 256; b++)
        do_group(1, 8'(b), s[0]);
    // grayscale sweep, strobe every dot
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 256; b++)
        do_group(2, 8'(b), s[0]);

    // R11 hold without strobe
    do_group(2, 8'hFF, 1'b1);
    data = 8'h03;
    sync = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(lvl_g == 5'd31, "R11 hold level", lvl_g, 31);
      chk(blk_g == 1'b0, "R11 hold blank", blk_g, 0);
    end

    // R6 explicit pair: last bit 1 then first bit 1 with no gap
    do_group(0, 8'h0F, 1'b1);
    do_group(0, 8'hFB, 1'b1);
    do_group(1, 8'h0F, 1'b1);
    do_group(1, 8'h8B, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule